// File: doc/BRIEF.md
# Indexed Byte-to-Word Register Bridge

This bridge sits behind the byte layer of a two-wire serial slave. It turns a stream of short byte pairs into 32-bit accesses on a simple register bus. Each host access is a pair of bytes. The first is an index byte. The second is either a data byte written to that index or a one-byte read of that index. A start pulse from the byte layer puts the pairing back at the index byte.

The host first stages a word address and a write word, one byte per index. It then writes a command byte, which starts a single bus write or a single bus read. The host polls a status index until that index reads zero. After a read completes, the host collects the fetched word one byte at a time from four further indexes.

On the bus side the block is the request owner. It holds a request until the bus accepts it, then waits for an acknowledge pulse. For a read, the data arrives with that pulse.

Top module: `idx_word_bridge`

## Requirements
- R1: A data byte written to index 0x00, 0x01, 0x02 or 0x03 is stored as byte 0, 1, 2 or 3 of the staged address, where byte 0 is the least significant. Reading those indexes returns the stored bytes.
- R2: A data byte written to index 0x04 to 0x07 is stored as byte 0 to 3 of the staged write word, least significant at 0x04. Reading those indexes returns the stored bytes.
- R3: Writing 0x01 to index 0x0C while idle issues exactly one bus request with bus_we=1, carrying the staged address and the staged write word.
- R4: Writing 0x00 to index 0x0C while idle issues exactly one bus request with bus_we=0 at the staged address. After the acknowledge, indexes 0x08 to 0x0B return the returned word, least significant byte at 0x08.
- R5: Index 0x0F reads 0x01 from the launch until the acknowledge has been taken, and reads 0x00 otherwise.
- R6: A command byte written while an access is in progress, or a command value other than 0x00 or 0x01, starts no bus request. While the access is in progress, the status byte stays nonzero.
- R7: Indexes other than 0x00 to 0x0C and 0x0F read as 0x00. Writes to them change no staged byte and start no bus access.
- R8: The first written byte after reset, after a start pulse, or after a completed pair is taken as an index. The next written byte, or the next read, completes the pair. A read returns its byte on rd_byte with rd_valid one cycle after rd_stb.
- R9: While bus_valid is high and bus_ready is low, bus_valid, bus_we, bus_addr and bus_wdata hold steady.
- R10: After reset, no request is pending, every staged and fetched byte reads 0x00, and the status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Start pulse from the byte layer; puts the pairing back at the index byte |
| wr_stb | input | 1 | A written byte is present on wr_byte |
| wr_byte | input | 8 | Byte written by the host |
| rd_stb | input | 1 | Host reads one byte at the current index |
| rd_byte | output | 8 | Byte returned for the read |
| rd_valid | output | 1 | rd_byte is valid, one cycle after rd_stb |
| bus_valid | output | 1 | Bus request pending |
| bus_ready | input | 1 | Bus accepts the request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Word address |
| bus_wdata | output | 32 | Write word |
| bus_rdata | input | 32 | Read word, valid together with bus_ack |
| bus_ack | input | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the bus. An acknowledge comes only after a request has been accepted. At most one acknowledge arrives per request. bus_ready is sampled only while bus_valid is high. The bench responder keeps to these rules: it raises ready at random only while a request is pending, and it issues exactly one acknowledge after a random delay once a request has been taken. The host stimulus keeps every access a proper byte pair and never sends a write strobe and a read strobe in the same cycle. On that base, the random accesses and the directed cases look at the pairing rules, the handling of commands while busy, and the undefined indexes.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {BM_IDLE, BM_REQ, BM_WAIT} bm_state_t;
  localparam logic [7:0] IDX_CMD  = 8'h0C;
  localparam logic [7:0] IDX_STAT = 8'h0F;
  localparam logic [7:0] CMD_WR   = 8'h01;
  localparam logic [7:0] CMD_RD   = 8'h00;
endpackage

// File: rtl/byte_pairer.sv
module byte_pairer (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       rd_stb,
  output logic [7:0] idx_q,
  output logic       have_idx,
  output logic       data_wr,
  output logic       rd_req
);
  // a written byte completes a pair only when an index is already held
  assign data_wr = wr_stb && have_idx && !frame_start;
  assign rd_req  = rd_stb && have_idx && !frame_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      have_idx <= 1'b0;
    end else if (frame_start) begin
      have_idx <= 1'b0;
    end else if (wr_stb) begin
      if (!have_idx) begin
        idx_q    <= wr_byte;
        have_idx <= 1'b1;
      end else begin
        have_idx <= 1'b0;
      end
    end else if (rd_stb) begin
      have_idx <= 1'b0;
    end
  end
endmodule

// File: rtl/stage_regs.sv
module stage_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic [7:0]        idx,
  input  logic [7:0]        data_byte,
  input  logic              rd_stb,
  input  logic              rd_req,
  input  logic              busy,
  input  logic              rdata_load,
  input  logic [DATA_W-1:0] rdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [7:0]        rd_byte,
  output logic              rd_valid
);
  import bridge_pkg::*;
  localparam int AB     = ADDR_W / 8;
  localparam int DB     = DATA_W / 8;
  localparam int WD_BASE = AB;
  localparam int RD_BASE = AB + DB;

  logic [DATA_W-1:0] rdata_q;
  logic [7:0]        mux;

  for (genvar b = 0; b < AB; b++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst) addr_q[8*b +: 8] <= '0;
      else if (data_wr && idx == 8'(b)) addr_q[8*b +: 8] <= data_byte;
    end
  end

  for (genvar b = 0; b < DB; b++) begin : g_wdata
    always_ff @(posedge clk) begin
      if (rst) wdata_q[8*b +: 8] <= '0;
      else if (data_wr && idx == 8'(WD_BASE + b)) wdata_q[8*b +: 8] <= data_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rdata_load) rdata_q <= rdata_in;
  end

  always_comb begin
    mux = 8'h00;
    for (int b = 0; b < AB; b++)
      if (idx == 8'(b)) mux = addr_q[8*b +: 8];
    for (int b = 0; b < DB; b++) begin
      if (idx == 8'(WD_BASE + b)) mux = wdata_q[8*b +: 8];
      if (idx == 8'(RD_BASE + b)) mux = rdata_q[8*b +: 8];
    end
    if (idx == IDX_STAT) mux = {7'b0, busy};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_byte <= rd_req ? mux : 8'h00;
    end
  end
endmodule

// File: rtl/bus_master.sv
module bus_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [ADDR_W-1:0] stage_addr,
  input  logic [DATA_W-1:0] stage_wdata,
  input  logic              bus_ready,
  input  logic              bus_ack,
  output logic              bus_valid,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              busy,
  output logic              rdata_load
);
  import bridge_pkg::*;
  bm_state_t state;

  assign busy       = (state != BM_IDLE);
  assign rdata_load = (state == BM_WAIT) && bus_ack && !bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= BM_IDLE;
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      case (state)
        BM_IDLE: if (launch) begin
          state     <= BM_REQ;
          bus_valid <= 1'b1;
          bus_we    <= launch_we;
          bus_addr  <= stage_addr;
          bus_wdata <= stage_wdata;
        end
        BM_REQ: if (bus_ready) begin
          state     <= BM_WAIT;
          bus_valid <= 1'b0;
        end
        BM_WAIT: if (bus_ack) state <= BM_IDLE;
        default: state <= BM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_word_bridge.sv
module idx_word_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              wr_stb,
  input  logic [7:0]        wr_byte,
  input  logic              rd_stb,
  output logic [7:0]        rd_byte,
  output logic              rd_valid,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  import bridge_pkg::*;

  logic [7:0]        idx_q;
  logic              have_idx, data_wr, rd_req, busy, rdata_load, launch;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  byte_pairer u_pair (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .idx_q(idx_q), .have_idx(have_idx),
    .data_wr(data_wr), .rd_req(rd_req)
  );

  assign launch = data_wr && (idx_q == IDX_CMD) &&
                  (wr_byte == CMD_WR || wr_byte == CMD_RD);

  stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .data_wr(data_wr), .idx(idx_q), .data_byte(wr_byte),
    .rd_stb(rd_stb), .rd_req(rd_req), .busy(busy), .rdata_load(rdata_load),
    .rdata_in(bus_rdata), .addr_q(addr_q), .wdata_q(wdata_q),
    .rd_byte(rd_byte), .rd_valid(rd_valid)
  );

  bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk(clk), .rst(rst), .launch(launch), .launch_we(wr_byte == CMD_WR),
    .stage_addr(addr_q), .stage_wdata(wdata_q), .bus_ready(bus_ready),
    .bus_ack(bus_ack), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .rdata_load(rdata_load)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              rd_valid,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              busy
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_we) &&
                                $stable(bus_addr) && $stable(bus_wdata));

  assert_one_request_R3: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ready |=> !bus_valid);

  assert_launch_from_host_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(wr_stb));

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_stb));

  assert_done_on_ack_R5: assert property (@(posedge clk) disable iff (rst)
    busy && !bus_valid && bus_ack |=> !busy);

  assert_busy_while_req_R5: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> busy);
endmodule

bind idx_word_bridge bridge_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_valid(rd_valid),
  .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .busy(u_master.busy)
);

// File: tb/tb_idx_word_bridge.sv
module tb_idx_word_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic [7:0]  rd_byte;
  logic        rd_valid, bus_valid, bus_we;
  logic        bus_ready = 1'b0, bus_ack = 1'b0;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // responder state
  logic [31:0] rmem [16];
  logic [31:0] exp_mem [16];
  int          extra_dly = 0;
  bit          hs_pend = 0, pend = 0;
  int          dly = 0, txn_cnt = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic        cap_we;

  idx_word_bridge dut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] seed_word(int k);
    return 32'h9E37_79B9 * (k + 1) ^ 32'h0F0F_1234;
  endfunction

  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (hs_pend) begin
      hs_pend = 0;
      pend = 1;
      dly = extra_dly + int'($urandom % 4);
      txn_cnt++;
      if (cap_we) rmem[cap_addr[5:2]] = cap_wdata;
    end
    if (pend) begin
      if (dly == 0) begin
        bus_ack = 1'b1;
        bus_rdata = cap_we ? 32'hDEAD_BEEF : rmem[cap_addr[5:2]];
        pend = 0;
      end else dly--;
    end
    if (bus_valid && !pend && !hs_pend) begin
      bus_ready = 1'($urandom % 2);
      if (bus_ready) begin
        hs_pend = 1; cap_addr = bus_addr; cap_we = bus_we; cap_wdata = bus_wdata;
      end
    end else bus_ready = 1'b0;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_pair(logic [7:0] idx, logic [7:0] val);
    @(negedge clk); wr_stb = 1; wr_byte = idx;
    @(negedge clk); wr_byte = val;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd_pair(logic [7:0] idx, output logic [7:0] val);
    @(negedge clk); wr_stb = 1; wr_byte = idx;
    @(negedge clk); wr_stb = 0; rd_stb = 1;
    @(negedge clk); rd_stb = 0; val = rd_byte;
  endtask

  task automatic stage(logic [31:0] a, logic [31:0] d);
    for (int b = 0; b < 4; b++) wr_pair(8'(b), a[8*b +: 8]);
    for (int b = 0; b < 4; b++) wr_pair(8'(4 + b), d[8*b +: 8]);
  endtask

  task automatic poll(output int polls);
    logic [7:0] s;
    polls = 0;
    do begin rd_pair(8'h0F, s); polls++; end while (s != 0 && polls < 300);
    chk("R5 status returns to zero", 32'(s), 0);
  endtask

  task automatic rd_word(output logic [31:0] w);
    logic [7:0] b8;
    for (int b = 0; b < 4; b++) begin rd_pair(8'(8 + b), b8); w[8*b +: 8] = b8; end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] w, a, d;
    int          p, t0;
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) begin rmem[k] = seed_word(k); exp_mem[k] = seed_word(k); end
    repeat (4) @(negedge clk);
    rst = 0;

    // R10 reset state
    chk("R10 bus_valid after reset", 32'(bus_valid), 0);
    for (int i = 0; i < 12; i++) begin rd_pair(8'(i), v); chk("R10 reset byte", 32'(v), 0); end
    rd_pair(8'h0F, v); chk("R10 status after reset", 32'(v), 0);

    // R1 R2 staging readback
    stage(32'h1122_3344, 32'hA1B2_C3D4);
    for (int b = 0; b < 4; b++) begin
      rd_pair(8'(b), v); chk("R1 address byte", 32'(v), 32'(8'(32'h1122_3344 >> (8*b))));
      rd_pair(8'(4+b), v); chk("R2 write byte", 32'(v), 32'(8'(32'hA1B2_C3D4 >> (8*b))));
    end

    // R7 undefined indexes
    t0 = txn_cnt;
    wr_pair(8'h0D, 8'h55); wr_pair(8'h0E, 8'h01); wr_pair(8'h40, 8'h01);
    rd_pair(8'h0D, v); chk("R7 undefined read 0x0D", 32'(v), 0);
    rd_pair(8'hFF, v); chk("R7 undefined read 0xFF", 32'(v), 0);
    rd_pair(8'h00, v); chk("R7 staging untouched", 32'(v), 32'h44);
    repeat (5) @(negedge clk);
    chk("R7 no bus access", 32'(txn_cnt), 32'(t0));

    // R6 bad command value
    wr_pair(8'h0C, 8'h07);
    repeat (5) @(negedge clk);
    chk("R6 bad command no access", 32'(txn_cnt), 32'(t0));

    // R8 start pulse resyncs pairing
    @(negedge clk); wr_stb = 1; wr_byte = 8'h04;
    @(negedge clk); wr_stb = 0; frame_start = 1;
    @(negedge clk); frame_start = 0;
    wr_pair(8'h05, 8'h77);
    rd_pair(8'h04, v); chk("R8 index kept after start", 32'(v), 32'hD4);
    rd_pair(8'h05, v); chk("R8 new pair after start", 32'(v), 32'h77);

    // R6 command while busy
    extra_dly = 20;
    stage(32'h0000_0014, 32'h5A5A_0001);
    t0 = txn_cnt;
    wr_pair(8'h0C, 8'h00);
    wr_pair(8'h0C, 8'h01);
    rd_pair(8'h0F, v); chk("R6 status busy", 32'(v != 0), 1);
    poll(p);
    chk("R6 single access", 32'(txn_cnt), 32'(t0 + 1));
    chk("R6 first command kept", 32'(cap_we), 0);
    rd_word(w); chk("R4 read word", w, exp_mem[5]);
    extra_dly = 0;

    // random accesses
    for (int it = 0; it < 40; it++) begin
      a = {$urandom % 16, 2'b00} | ($urandom & 32'hFFFF_FFC0);
      d = $urandom;
      stage(a, d);
      t0 = txn_cnt;
      if ($urandom % 2) begin
        wr_pair(8'h0C, 8'h01);
        poll(p);
        exp_mem[a[5:2]] = d;
        chk("R3 write count", 32'(txn_cnt), 32'(t0 + 1));
        chk("R3 write flag", 32'(cap_we), 1);
        chk("R3 write address", cap_addr, a);
        chk("R3 write data", cap_wdata, d);
      end else begin
        wr_pair(8'h0C, 8'h00);
        poll(p);
        chk("R4 read count", 32'(txn_cnt), 32'(t0 + 1));
        chk("R4 read address", cap_addr, a);
        rd_word(w); chk("R4 read word", w, exp_mem[a[5:2]]);
      end
    end
    finish_run();
  end
endmodule